// File: doc/BRIEF.md
# Digit-Serial Decimal Subtractor with Recomplement

The block adds or subtracts two unsigned packed-BCD numbers of `N` digits, one decimal digit per clock, starting from the least significant digit. The caller does not hand over whole operands. The block shows the position it needs on `dig_idx`, and the caller puts the matching minuend/augend digit on `x_dig` and the subtrahend/addend digit on `y_dig`. Subtraction adds the nines complement of each `y_dig` and presets the digit carry to one before the lowest digit, so the sum of that first pass is X + (10^N - Y).

If a subtraction ends with no carry out of the top digit, the stored first-pass answer is a complement. The block then runs a second digit-serial pass over its own result store and takes no operand input in that pass. Each stored digit is nines-complemented and goes in on the B side of the adder. The A side carries the constant one at digit 0 and zero at every higher digit, and the carry starts at zero. The second pass therefore writes the tens complement of the first answer, which is the true magnitude Y - X, and it sets the negative flag.

The controller has four states:
- `ST_IDLE` waits for `start`.
- `ST_MAIN` runs the first pass.
- `ST_RECOMP` runs the second pass.
- `ST_DONE` raises `done` for one cycle.

It has five transitions:
- From `ST_IDLE` to `ST_MAIN` on `start`.
- From `ST_MAIN` to `ST_RECOMP` after the last digit of a subtraction with no final carry.
- From `ST_MAIN` to `ST_DONE` after the last digit in every other case.
- From `ST_RECOMP` to `ST_DONE` after the last digit.
- From `ST_DONE` to `ST_IDLE` unconditionally.

Top module: `dsr_top`

## Requirements
- R1: After reset, `busy`, `done`, `negative` and `overflow` are 0 and `result` is all zeros.
- R2: With `op_sub`=0 (add), the block gives `result` = (X+Y) mod 10^N in packed BCD, with digit i in bits [4i+3:4i]. `overflow` equals the carry out of the top digit, and `negative` is 0.
- R3: With `op_sub`=1 and X > Y, `result` = X-Y, and `negative` and `overflow` are 0.
- R4: With `op_sub`=1 and X < Y, a recomplement pass runs, and then `result` = Y-X with `negative` = 1 and `overflow` = 0. The operand inputs are ignored during that pass.
- R5: With `op_sub`=1 and X = Y, `result` is zero and `negative` is 0.
- R6: During the first pass, `dig_idx` shows 0, 1, ..., N-1 in successive cycles, and the digits on `x_dig` and `y_dig` are taken for that position in that cycle.
- R7: If `start` is sampled at edge E0, `busy` is high after edges E0 through E(T-1) and `done` is high only after edge ET. T is N when no recomplement pass runs and 2N when one runs. `busy` and `done` are never high together, and `done` lasts one cycle.
- R8: A `start` pulse while the block is busy is ignored. The running operation keeps its timing and its result.
- R9: Every digit written to the result store is a valid BCD digit (0 to 9). A raw digit sum above 9 is corrected by adding 6, and that correction produces a carry into the next digit.
- R10: `negative` can be 1 only after a subtraction, and `overflow` can be 1 only after an addition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the block is idle |
| op_sub | input | 1 | 1 = subtract Y from X, 0 = add, sampled with `start` |
| x_dig | input | 4 | Digit of X at position `dig_idx` |
| y_dig | input | 4 | Digit of Y at position `dig_idx` |
| dig_idx | output | IDXW | Digit position being processed |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse after the final pass; result and flags are valid |
| result | output | 4*N | Packed BCD result |
| negative | output | 1 | The result is the magnitude of a negative difference |
| overflow | output | 1 | The addition carried out of the top digit |

## Verification
The bench aims at these corner cases:
- A minuend that is one below the subtrahend, such as 0 - 1. The complement is then all nines except the lowest digit, and the recomplement carry must not ripple. A block that injects both the constant one and a forced carry would return 2 instead of 1.
- Equal operands. These must end positive after a single pass. A block that tested the wrong carry would run a needless second pass, which shows up as late timing and a negative zero.
- Garbage on the operand inputs throughout every recomplement pass. A design that reads the inputs instead of its store would produce a wrong magnitude.
- A `start` pulse with the opposite operation in the middle of a busy run. This exposes an FSM that restarts.
- All-nines additions. These check the decimal correction carry and the overflow flag.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_MAIN   = 2'd1,
        ST_RECOMP = 2'd2,
        ST_DONE   = 2'd3
    } dsr_state_e;

    localparam logic [3:0] BCD_MAX = 4'd9;

    function automatic logic [3:0] nines(input logic [3:0] d);
        return BCD_MAX - d;
    endfunction

endpackage

// File: rtl/dsr_digit_add.sv
module dsr_digit_add (
    input  logic [3:0] a_dig,
    input  logic [3:0] b_dig,
    input  logic       cin,
    output logic [3:0] sum_dig,
    output logic       cout
);
    logic [4:0] raw;
    logic [4:0] fixed;

    always_comb begin
        raw   = {1'b0, a_dig} + {1'b0, b_dig} + {4'b0, cin};
        fixed = raw + 5'd6;
        if (raw > 5'd9) begin
            sum_dig = fixed[3:0];
            cout    = 1'b1;
        end else begin
            sum_dig = raw[3:0];
            cout    = 1'b0;
        end
    end
endmodule

// File: rtl/dsr_store.sv
module dsr_store #(
    parameter int N    = 8,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [IDXW-1:0] idx,
    input  logic [3:0]      wr_dig,
    output logic [3:0]      rd_dig,
    output logic [4*N-1:0]  packed_q
);
    logic [3:0] dig_q [N];

    for (genvar i = 0; i < N; i++) begin : g_dig
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dig_q[i] <= 4'd0;
            end else if (wr_en && (idx == IDXW'(i))) begin
                dig_q[i] <= wr_dig;
            end
        end
        assign packed_q[4*i +: 4] = dig_q[i];
    end

    always_comb begin
        rd_dig = 4'd0;
        for (int k = 0; k < N; k++) begin
            if (idx == IDXW'(k)) rd_dig = dig_q[k];
        end
    end
endmodule

// File: rtl/dsr_ctrl.sv
module dsr_ctrl
    import dsr_pkg::*;
#(
    parameter int N    = 8,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            op_sub,
    input  logic            dig_cout,
    output logic [IDXW-1:0] idx,
    output logic            carry,
    output logic            recomp,
    output logic            sub_mode,
    output logic            wr_en,
    output logic            busy,
    output logic            done,
    output logic            negative,
    output logic            overflow
);
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(N - 1);

    dsr_state_e      state_q, state_d;
    logic [IDXW-1:0] idx_q, idx_d;
    logic            carry_q, carry_d;
    logic            sub_q, sub_d;
    logic            neg_q, neg_d;
    logic            ovf_q, ovf_d;
    logic            last;

    assign last = (idx_q == LAST_IDX);

    // State register and its companion data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            carry_q <= 1'b0;
            sub_q   <= 1'b0;
            neg_q   <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            carry_q <= carry_d;
            sub_q   <= sub_d;
            neg_q   <= neg_d;
            ovf_q   <= ovf_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        carry_d = carry_q;
        sub_d   = sub_q;
        neg_d   = neg_q;
        ovf_d   = ovf_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_MAIN;
                    idx_d   = '0;
                    carry_d = op_sub;
                    sub_d   = op_sub;
                    neg_d   = 1'b0;
                    ovf_d   = 1'b0;
                end
            end
            ST_MAIN: begin
                carry_d = dig_cout;
                if (last) begin
                    idx_d = '0;
                    if (sub_q && !dig_cout) begin
                        state_d = ST_RECOMP;
                        carry_d = 1'b0;
                    end else begin
                        state_d = ST_DONE;
                        ovf_d   = !sub_q && dig_cout;
                    end
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_RECOMP: begin
                carry_d = dig_cout;
                if (last) begin
                    idx_d   = '0;
                    state_d = ST_DONE;
                    neg_d   = 1'b1;
                end else begin
                    idx_d = idx_q + 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        busy   = 1'b0;
        done   = 1'b0;
        recomp = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_MAIN:   busy = 1'b1;
            ST_RECOMP: begin
                busy   = 1'b1;
                recomp = 1'b1;
            end
            ST_DONE:   done = 1'b1;
            default:   ;
        endcase
        wr_en    = busy;
        idx      = idx_q;
        carry    = carry_q;
        sub_mode = sub_q;
        negative = neg_q;
        overflow = ovf_q;
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (idx_q <= LAST_IDX));

    assert_first_digit_after_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MAIN && idx_q == '0) |-> ($past(state_q) == ST_IDLE));

    assert_recomp_after_full_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOMP && $past(state_q) == ST_MAIN) |-> ($past(idx_q) == LAST_IDX));

    assert_neg_needs_sub_R10: assert property (@(posedge clk) disable iff (!rst_n)
        negative |-> sub_q);

    assert_ovf_needs_add_R10: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> !sub_q);
endmodule

// File: rtl/dsr_top.sv
module dsr_top
    import dsr_pkg::*;
#(
    parameter int N    = 8,
    parameter int IDXW = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            op_sub,
    input  logic [3:0]      x_dig,
    input  logic [3:0]      y_dig,
    output logic [IDXW-1:0] dig_idx,
    output logic            busy,
    output logic            done,
    output logic [4*N-1:0]  result,
    output logic            negative,
    output logic            overflow
);
    logic [IDXW-1:0] idx;
    logic            carry, recomp, sub_mode, wr_en;
    logic [3:0]      a_path, b_path, sum_dig, stored_dig;
    logic            dig_cout;

    dsr_ctrl #(.N(N), .IDXW(IDXW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_sub   (op_sub),
        .dig_cout (dig_cout),
        .idx      (idx),
        .carry    (carry),
        .recomp   (recomp),
        .sub_mode (sub_mode),
        .wr_en    (wr_en),
        .busy     (busy),
        .done     (done),
        .negative (negative),
        .overflow (overflow)
    );

    // Operand paths: first pass takes the caller's digits,
    // recomplement pass takes the stored digit and the constant one.
    always_comb begin
        if (recomp) begin
            a_path = (idx == '0) ? 4'd1 : 4'd0;
            b_path = nines(stored_dig);
        end else begin
            a_path = x_dig;
            b_path = sub_mode ? nines(y_dig) : y_dig;
        end
    end

    dsr_digit_add u_add (
        .a_dig   (a_path),
        .b_dig   (b_path),
        .cin     (carry),
        .sum_dig (sum_dig),
        .cout    (dig_cout)
    );

    dsr_store #(.N(N), .IDXW(IDXW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .idx      (idx),
        .wr_dig   (sum_dig),
        .rd_dig   (stored_dig),
        .packed_q (result)
    );

    assign dig_idx = idx;

    assert_digit_bcd_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (sum_dig <= 4'd9));

    assert_recomp_stable_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (recomp && $past(recomp) && idx != '0) |-> (idx == $past(idx) + 1'b1));
endmodule

// File: tb/sim_dsr_top.sv
module sim_dsr_top;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int IDXW = 3;
    localparam longint MODV = 64'd100000000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic            op_sub = 1'b0;
    logic [3:0]      x_dig = 4'd0;
    logic [3:0]      y_dig = 4'd0;
    logic [IDXW-1:0] dig_idx;
    logic            busy, done, negative, overflow;
    logic [4*N-1:0]  result;

    int errors = 0;
    int checks = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dsr_top #(.N(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sub(op_sub),
        .x_dig(x_dig), .y_dig(y_dig), .dig_idx(dig_idx), .busy(busy),
        .done(done), .result(result), .negative(negative), .overflow(overflow)
    );

    function automatic logic [3:0] digit_of(longint v, int i);
        longint t = v;
        for (int k = 0; k < i; k++) t = t / 10;
        return 4'(t % 10);
    endfunction

    function automatic logic [4*N-1:0] to_bcd(longint v);
        logic [4*N-1:0] r = '0;
        for (int k = 0; k < N; k++) r[4*k +: 4] = digit_of(v, k);
        return r;
    endfunction

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Cycle-by-cycle reference: expected busy/done per edge, expected result at done.
    task automatic run_op(longint x, longint y, bit sub, bit poke, string req);
        longint exp_val;
        bit     exp_neg, exp_ovf;
        int     t;
        if (!sub) begin
            exp_val = (x + y) % MODV;
            exp_ovf = (x + y) >= MODV;
            exp_neg = 1'b0;
            t = N;
        end else if (x >= y) begin
            exp_val = x - y; exp_ovf = 1'b0; exp_neg = 1'b0; t = N;
        end else begin
            exp_val = y - x; exp_ovf = 1'b0; exp_neg = 1'b1; t = 2 * N;
        end
        @(negedge clk);
        start  = 1'b1;
        op_sub = sub;
        x_dig  = digit_of(x, 0);
        y_dig  = digit_of(y, 0);
        for (int j = 0; j <= t + 1; j++) begin
            @(negedge clk);
            if (j == 0) start = 1'b0;
            if (poke && j == 2) begin start = 1'b1; op_sub = ~sub; end
            if (poke && j == 3) start = 1'b0;
            if (j < N) begin
                check(dig_idx == IDXW'(j), "R6", "digit position", longint'(dig_idx), longint'(j));
                x_dig = digit_of(x, j);
                y_dig = digit_of(y, j);
            end else begin
                // R4: operand inputs carry noise during the recomplement pass
                x_dig = 4'($urandom_range(9));
                y_dig = 4'($urandom_range(9));
            end
            if (j <= t) begin
                check(busy == (j < t), poke ? "R8" : "R7", "busy", longint'(busy), longint'(j < t));
                check(done == (j == t), poke ? "R8" : "R7", "done", longint'(done), longint'(j == t));
            end else begin
                check(!busy && !done, "R7", "idle after done", longint'({busy, done}), 0);
            end
            if (j == t) begin
                check(result == to_bcd(exp_val), req, "result", longint'(result), longint'(to_bcd(exp_val)));
                check(negative == exp_neg, req, "negative", longint'(negative), longint'(exp_neg));
                check(overflow == exp_ovf, req, "overflow (R10)", longint'(overflow), longint'(exp_ovf));
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done, "R1", "reset busy/done", longint'({busy, done}), 0);
        check(result == '0, "R1", "reset result", longint'(result), 0);
        check(!negative && !overflow, "R1", "reset flags", longint'({negative, overflow}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        run_op(27, 52, 1'b1, 1'b0, "R4");          // 27-52 -> 25 minus
        run_op(52, 27, 1'b1, 1'b0, "R3");
        run_op(4711, 4711, 1'b1, 1'b0, "R5");
        run_op(0, 0, 1'b1, 1'b0, "R5");
        run_op(0, 1, 1'b1, 1'b0, "R4");
        run_op(0, 99999999, 1'b1, 1'b0, "R4");
        run_op(99999999, 0, 1'b1, 1'b0, "R3");
        run_op(99999999, 1, 1'b0, 1'b0, "R2");     // overflow, R9 carry ripple
        run_op(99999999, 99999999, 1'b0, 1'b0, "R2");
        run_op(0, 0, 1'b0, 1'b0, "R2");
        run_op(12345678, 55555555, 1'b0, 1'b0, "R9");
        run_op(1234, 98765432, 1'b1, 1'b1, "R8");
        run_op(98765432, 1234, 1'b0, 1'b1, "R8");
        for (int n = 0; n < 40; n++) begin
            longint x = longint'($urandom % 32'd100000000);
            longint y = longint'($urandom % 32'd100000000);
            bit s = 1'($urandom_range(1));
            run_op(x, y, s, 1'b0, s ? (x >= y ? "R3" : "R4") : "R2");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule